// File: doc/BRIEF.md
# Clock Recovery Training Sequencer

This block runs the clock-recovery phase of link training for one receiver on a serial display link of up to four lanes. A controller pulses `start` and reports two things about the receiver: whether its protocol revision is 1.4 or newer, and how many lanes are in use. The sequencer first clears every lane's drive setting to zero. It then issues one write carrying training pattern 1, with scrambling disabled, together with the zeroed settings.

After that write it repeats one loop. It starts an external delay timer and waits for it to expire. It reads the lane status. If every active lane has locked its clock, it stops. Otherwise it derives one new drive setting from the receiver's per-lane adjustment requests and writes that setting back.

The phase fails in any of these cases:
- a request is refused,
- the iteration budget runs out,
- lane 0's swing has been tried five times in a row,
- the previous update already left the lanes at maximum swing.

All link traffic goes through a single request/response port. The physical auxiliary-channel signalling is handled elsewhere.

Top module: `cr_train_seq`

## Requirements
- R1: When `start` is seen while idle, the block issues a request of kind 1 (write pattern and settings) with `req_pat` = 0x21 (pattern 1 in bits [1:0], scrambling-disable in bit 5) and all setting bytes zero. If that request returns `resp_ok`=0, the phase ends with `done` and `pass`=0, and no status read takes place.
- R2: The loop runs at most 10 iterations when `rev_ge_14`=1 and at most 80 when it is 0. When the budget is used up, the phase fails.
- R3: Each iteration first pulses `dly_start` and waits for `dly_done`, and only then issues a status read (kind 0). A status read answered with `resp_ok`=0 fails the phase.
- R4: In the status word, `resp_rdata` bit 4*i is lane i's clock-recovery-done flag, so lanes 0/1 share byte 0 and lanes 2/3 share byte 1. When the flag is set on every active lane, the phase ends with `pass`=1. Flags on inactive lanes are ignored. `lane_cfg` 0 means 1 lane, 1 means 2 lanes, and 2 or 3 means 4 lanes.
- R5: A same-swing count starts at 1. After each successful settings write it increments if lane 0's swing is unchanged and otherwise returns to 1. A status check that finds the count at 5, without clock recovery, fails the phase.
- R6: If the last written setting carried the maximum-swing flag and clock recovery is still not done on the next status read, the phase fails.
- R7: Lane i's adjustment request sits in `resp_rdata` [16+4i+3 : 16+4i], with swing in bits [1:0] and pre-emphasis in bits [3:2]. The new setting is built in these steps:
  - Take the highest swing and the highest pre-emphasis over the active lanes; inactive lanes are ignored.
  - Clamp pre-emphasis to 3 and set flag bit 5 when it reaches 3.
  - Limit swing to 3 minus pre-emphasis, then clamp it to 3 and set flag bit 2 when it reaches 3.
  - Pack the byte as {00, flag5, pre[1:0], flag2, swing[1:0]}.
  - Write this byte to all four lanes with a kind-2 request.
- R8: A settings write (kind 2) that returns `resp_ok`=0 fails the phase.
- R9: `done` is a one-cycle pulse, and `pass` holds the result until the next start. A `start` pulse while `busy` has no effect.
- R10: Under reset, and afterwards whenever the block is idle, `busy`, `done`, `pass`, `req_valid` and `dly_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a clock-recovery phase |
| rev_ge_14 | input | 1 | Receiver revision is 1.4 or newer |
| lane_cfg | input | 2 | Active lanes: 0→1, 1→2, 2/3→4 |
| busy | output | 1 | Phase in progress |
| done | output | 1 | One-cycle end-of-phase pulse |
| pass | output | 1 | Result of the last phase |
| req_valid | output | 1 | Request pending, held until response |
| req_kind | output | 2 | 0 status read, 1 pattern+settings write, 2 settings write |
| req_pat | output | 8 | Pattern byte for kind 1 |
| req_wdata | output | 32 | Four lane setting bytes, lane 0 in [7:0] |
| resp_valid | input | 1 | Response strobe |
| resp_ok | input | 1 | Request succeeded |
| resp_rdata | input | 32 | Status nibbles [15:0], adjustment nibbles [31:16] |
| dly_start | output | 1 | Start the wait timer |
| dly_done | input | 1 | Wait timer expired |

## Verification
- **Requests:** A request appears on the first cycle after the state that issues it. It stays up until the cycle after `resp_valid`.
- **Delay timer:** The bench answers every request at the falling edge after it first sees it. It raises `dly_done` two falling edges after `dly_start`.
- **End of phase:** `done` and the final `pass` appear on the cycle after the deciding response or status check. The bench polls for them at falling edges and checks `done` again one cycle later, to confirm the pulse has ended.
- **Drive settings:** Each written setting byte is compared, at the moment the write is first seen, against a value derived from the adjustment requests that the bench itself returned in the preceding status read.

// File: rtl/crts_pkg.sv
// Package: shared encodings for the clock-recovery training sequencer.
// Assumes: at most four lanes and one setting byte per lane.
package crts_pkg;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_LOOP,
        ST_WAIT,
        ST_READ,
        ST_EVAL,
        ST_UPD
    } crts_state_e;

    // Request kinds on the link port.
    localparam logic [1:0] REQ_RD_STATUS = 2'd0;
    localparam logic [1:0] REQ_WR_ALL    = 2'd1;
    localparam logic [1:0] REQ_WR_LANES  = 2'd2;

    // Pattern 1 with scrambling disabled.
    localparam logic [7:0] PAT1_NOSCR = 8'h21;

    // Number of lanes selected by the lane configuration code.
    function automatic int unsigned lanes_of(input logic [1:0] cfg, input int unsigned max_lanes);
        case (cfg)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return max_lanes;
        endcase
    endfunction

endpackage

// File: rtl/crts_lane_check.sv
// Module: reduces the per-lane clock-recovery flags to one verdict.
// Assumes: bit 0 of each lane's status nibble is the lock flag; inactive lanes count as locked.
module crts_lane_check #(
    parameter int LANES = 4
) (
    input  logic [4*LANES-1:0] status,
    input  logic [LANES-1:0]   active,
    output logic               all_locked
);
    logic [LANES-1:0] lane_ok;
    logic [LANES-1:0] unused_hi;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            // Per-lane verdict: locked, or not part of the link.
            assign lane_ok[gi]   = status[4*gi] | ~active[gi];
            assign unused_hi[gi] = ^status[4*gi+3 -: 3];
        end
    endgenerate

    // All lanes must agree.
    assign all_locked = &lane_ok;

endmodule

// File: rtl/crts_adjust.sv
// Module: turns the receiver's per-lane adjustment requests into one drive byte.
// Assumes: 2-bit swing and pre-emphasis; swing plus pre-emphasis never exceeds 3.
module crts_adjust #(
    parameter int         LANES   = 4,
    parameter logic [1:0] SW_MAX  = 2'd3,
    parameter logic [1:0] PRE_MAX = 2'd3
) (
    input  logic [4*LANES-1:0] adj,
    input  logic [LANES-1:0]   active,
    output logic [7:0]         setting
);
    logic [1:0] sw;
    logic [1:0] pre;
    logic [1:0] sw_cap;
    logic       sw_flag;
    logic       pre_flag;

    // Highest request over active lanes, then clamp to the drive limits.
    always_comb begin
        sw  = 2'd0;
        pre = 2'd0;
        for (int i = 0; i < LANES; i++) begin
            if (active[i]) begin
                if (adj[4*i +: 2] > sw)    sw  = adj[4*i +: 2];
                if (adj[4*i+2 +: 2] > pre) pre = adj[4*i+2 +: 2];
            end
        end
        pre_flag = (pre >= PRE_MAX);
        if (pre_flag) pre = PRE_MAX;
        sw_cap = 2'd3 - pre;
        if (sw > sw_cap) sw = sw_cap;
        sw_flag = (sw >= SW_MAX);
        if (sw_flag) sw = SW_MAX;
        setting = {2'b00, pre_flag, pre, sw_flag, sw};
    end

endmodule

// File: rtl/cr_train_seq.sv
// Module: clock-recovery phase sequencer for one receiver of a multi-lane link.
// Assumes: one request outstanding at a time; the responder raises resp_valid for
// exactly one cycle per request; the delay timer answers every dly_start pulse.
module cr_train_seq
    import crts_pkg::*;
#(
    parameter int         LANES      = 4,
    parameter int         TRIES_NEW  = 10,
    parameter int         TRIES_OLD  = 80,
    parameter int         SAME_LIMIT = 5,
    parameter logic [1:0] SW_MAX     = 2'd3,
    parameter logic [1:0] PRE_MAX    = 2'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rev_ge_14,
    input  logic [1:0]         lane_cfg,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic               req_valid,
    output logic [1:0]         req_kind,
    output logic [7:0]         req_pat,
    output logic [8*LANES-1:0] req_wdata,
    input  logic               resp_valid,
    input  logic               resp_ok,
    input  logic [8*LANES-1:0] resp_rdata,
    output logic               dly_start,
    input  logic               dly_done
);
    localparam int TMAX = (TRIES_NEW > TRIES_OLD) ? TRIES_NEW : TRIES_OLD;
    localparam int ITW  = $clog2(TMAX + 1);
    localparam int SCW  = $clog2(SAME_LIMIT + 1);
    localparam int NIB  = 4 * LANES;

    crts_state_e        state;
    logic               rev_q;
    logic [LANES-1:0]   act_q;
    logic [LANES-1:0]   act_in;
    logic [7:0]         set_q;
    logic [7:0]         adj_set;
    logic [ITW-1:0]     iter_q;
    logic [ITW-1:0]     lim;
    logic [SCW-1:0]     same_q;
    logic               maxhit_q;
    logic [1:0]         saved_sw;
    logic [NIB-1:0]     stat_q;
    logic [NIB-1:0]     adjreq_q;
    logic               all_locked;
    logic               done_q;
    logic               pass_q;

    // Active-lane mask decoded from the configuration code.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            act_in[i] = (i < int'(lanes_of(lane_cfg, LANES)));
    end

    // Iteration budget chosen by receiver revision.
    assign lim = rev_q ? ITW'(TRIES_NEW) : ITW'(TRIES_OLD);

    crts_lane_check #(.LANES(LANES)) u_check (
        .status     (stat_q),
        .active     (act_q),
        .all_locked (all_locked)
    );

    crts_adjust #(.LANES(LANES), .SW_MAX(SW_MAX), .PRE_MAX(PRE_MAX)) u_adjust (
        .adj     (adjreq_q),
        .active  (act_q),
        .setting (adj_set)
    );

    // Phase control: sequencing, counters and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rev_q    <= 1'b0;
            act_q    <= '0;
            set_q    <= '0;
            iter_q   <= '0;
            same_q   <= SCW'(1);
            maxhit_q <= 1'b0;
            saved_sw <= '0;
            stat_q   <= '0;
            adjreq_q <= '0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        rev_q    <= rev_ge_14;
                        act_q    <= act_in;
                        set_q    <= '0;
                        iter_q   <= '0;
                        same_q   <= SCW'(1);
                        maxhit_q <= 1'b0;
                        pass_q   <= 1'b0;
                        state    <= ST_INIT;
                    end
                end
                ST_INIT: begin
                    if (resp_valid) begin
                        if (resp_ok) begin
                            state <= ST_LOOP;
                        end else begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_LOOP: begin
                    if (iter_q >= lim) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (dly_done) state <= ST_READ;
                end
                ST_READ: begin
                    if (resp_valid) begin
                        if (resp_ok) begin
                            stat_q   <= resp_rdata[NIB-1:0];
                            adjreq_q <= resp_rdata[2*NIB-1:NIB];
                            state    <= ST_EVAL;
                        end else begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_EVAL: begin
                    if (all_locked) begin
                        done_q <= 1'b1;
                        pass_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (same_q == SCW'(SAME_LIMIT) || maxhit_q) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        saved_sw <= set_q[1:0];
                        set_q    <= adj_set;
                        state    <= ST_UPD;
                    end
                end
                ST_UPD: begin
                    if (resp_valid) begin
                        if (resp_ok) begin
                            same_q   <= (set_q[1:0] == saved_sw) ? same_q + SCW'(1) : SCW'(1);
                            maxhit_q <= set_q[2];   // every lane carries this same byte
                            iter_q   <= iter_q + ITW'(1);
                            state    <= ST_LOOP;
                        end else begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port view of the state.
    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign pass      = pass_q;
    assign req_valid = (state == ST_INIT) || (state == ST_READ) || (state == ST_UPD);
    assign req_kind  = (state == ST_INIT) ? REQ_WR_ALL :
                       (state == ST_UPD)  ? REQ_WR_LANES : REQ_RD_STATUS;
    assign req_pat   = PAT1_NOSCR;
    assign req_wdata = {LANES{set_q}};
    assign dly_start = (state == ST_LOOP) && (iter_q < lim);

endmodule

// File: rtl/crts_checker.sv
// Module: protocol and bound checks on the sequencer's ports, bound to every instance.
// Assumes: the same parameters as the bound instance.
module crts_checker #(
    parameter int LANES     = 4,
    parameter int TRIES_NEW = 10,
    parameter int TRIES_OLD = 80
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               rev_ge_14,
    input logic               busy,
    input logic               done,
    input logic               req_valid,
    input logic [1:0]         req_kind,
    input logic [7:0]         req_pat,
    input logic [8*LANES-1:0] req_wdata,
    input logic               resp_valid,
    input logic               dly_start,
    input logic               dly_done
);
    logic [7:0] dly_cnt;
    logic       rev_seen;
    logic       waited;
    int         lim;

    assign lim = rev_seen ? TRIES_NEW : TRIES_OLD;

    // Track delay pulses per phase and whether a wait finished before a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_cnt  <= '0;
            rev_seen <= 1'b0;
            waited   <= 1'b0;
        end else if (start && !busy) begin
            dly_cnt  <= '0;
            rev_seen <= rev_ge_14;
            waited   <= 1'b0;
        end else begin
            if (dly_start) dly_cnt <= dly_cnt + 8'd1;
            if (dly_done && busy) waited <= 1'b1;
            else if (req_valid && req_kind == 2'd0 && resp_valid) waited <= 1'b0;
        end
    end

    a_r1_init_request: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (req_valid && req_kind == 2'd1 && req_pat == 8'h21 && req_wdata == '0));

    a_r2_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        dly_start |-> (int'(dly_cnt) < lim));

    a_r3_wait_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |-> waited);

    a_r7_lanes_identical: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |-> (req_wdata == {LANES{req_wdata[7:0]}}));

    a_r7_level_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |-> ({1'b0, req_wdata[1:0]} + {1'b0, req_wdata[4:3]} <= 3'd3));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!req_valid && !dly_start));

endmodule

bind cr_train_seq crts_checker #(
    .LANES     (LANES),
    .TRIES_NEW (TRIES_NEW),
    .TRIES_OLD (TRIES_OLD)
) u_crts_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rev_ge_14  (rev_ge_14),
    .busy       (busy),
    .done       (done),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_pat    (req_pat),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .dly_start  (dly_start),
    .dly_done   (dly_done)
);

// File: tb/test_cr_train_seq.sv
// Bench: vector table of phase scenarios driven through a modelled link and timer,
// followed by directed reset and restart tests.
module test_cr_train_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       rev;
        logic [1:0] cfg;
        logic [2:0] mode;      // adjustment-request pattern
        logic [7:0] cr_after;  // read index from which lock flags appear (0 = never)
        logic [3:0] cr_mask;   // lanes that report lock
        logic [7:0] fail_at;   // request index refused (0 = none)
        logic       exp_pass;
        logic [7:0] exp_reads;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd2, 3'd2, 8'd1, 4'hF, 8'd0, 1'b1, 8'd1},
        '{1'b1, 2'd2, 3'd2, 8'd3, 4'hF, 8'd0, 1'b1, 8'd3},
        '{1'b1, 2'd1, 3'd2, 8'd2, 4'h3, 8'd0, 1'b1, 8'd2},
        '{1'b1, 2'd2, 3'd2, 8'd2, 4'h3, 8'd0, 1'b0, 8'd10},
        '{1'b0, 2'd2, 3'd2, 8'd0, 4'h0, 8'd0, 1'b0, 8'd80},
        '{1'b1, 2'd2, 3'd0, 8'd0, 4'h0, 8'd0, 1'b0, 8'd5},
        '{1'b1, 2'd2, 3'd1, 8'd0, 4'h0, 8'd0, 1'b0, 8'd4},
        '{1'b1, 2'd2, 3'd2, 8'd0, 4'h0, 8'd1, 1'b0, 8'd0},
        '{1'b1, 2'd2, 3'd2, 8'd0, 4'h0, 8'd4, 1'b0, 8'd2},
        '{1'b1, 2'd2, 3'd2, 8'd0, 4'h0, 8'd3, 1'b0, 8'd1},
        '{1'b1, 2'd0, 3'd0, 8'd0, 4'h0, 8'd0, 1'b0, 8'd5},
        '{1'b1, 2'd2, 3'd3, 8'd0, 4'h0, 8'd0, 1'b0, 8'd6},
        '{1'b1, 2'd2, 3'd4, 8'd0, 4'h0, 8'd0, 1'b0, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rev_ge_14 = 1'b1;
    logic [1:0]  lane_cfg = 2'd2;
    logic        busy, done, pass, req_valid, dly_start;
    logic [1:0]  req_kind;
    logic [7:0]  req_pat;
    logic [31:0] req_wdata;
    logic        resp_valid = 1'b0;
    logic        resp_ok = 1'b0;
    logic [31:0] resp_rdata = '0;
    logic        dly_done = 1'b0;

    int   n_cmp = 0;
    int   n_mis = 0;
    int   req_n = 0;
    int   reads = 0;
    int   dcnt = 0;
    bit   finished = 1'b0;
    vec_t cur = '0;

    cr_train_seq i_cr_train_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rev_ge_14(rev_ge_14), .lane_cfg(lane_cfg),
        .busy(busy), .done(done), .pass(pass),
        .req_valid(req_valid), .req_kind(req_kind), .req_pat(req_pat), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_rdata(resp_rdata),
        .dly_start(dly_start), .dly_done(dly_done)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int lanes_n(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    // Adjustment nibble returned for an active lane on read n (swing [1:0], pre-emphasis [3:2]).
    function automatic logic [3:0] adj_nib(input logic [2:0] mode, input int n);
        case (mode)
            3'd1:    return (n >= 3) ? 4'h3 : 4'(n);
            3'd2:    return (n % 2 == 1) ? 4'h1 : 4'h0;
            3'd3:    return 4'hA;
            3'd4:    return 4'hF;
            default: return 4'h0;
        endcase
    endfunction

    // Expected setting byte per R7 after read n.
    function automatic logic [7:0] exp_set(input logic [2:0] mode, input int n);
        case (mode)
            3'd1:    return (n >= 3) ? 8'h07 : 8'(n);
            3'd2:    return (n % 2 == 1) ? 8'h01 : 8'h00;
            3'd3:    return 8'h11;
            3'd4:    return 8'h38;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string vtag(input int i);
        case (i)
            0, 1, 2: return "R4";
            3, 4:    return "R2";
            5, 11:   return "R5";
            6:       return "R6";
            7:       return "R1";
            8:       return "R3";
            9:       return "R8";
            default: return "R7";
        endcase
    endfunction

    // Link and timer model: answers at falling edges, checks written data.
    always @(negedge clk) begin
        if (!rst_n) begin
            resp_valid = 1'b0;
            dly_done   = 1'b0;
            dcnt       = 0;
        end else begin
            if (dly_start) dcnt = 3;
            else if (dcnt > 0) dcnt = dcnt - 1;
            dly_done = (dcnt == 1);
            if (req_valid && !resp_valid) begin
                req_n   = req_n + 1;
                resp_ok = (req_n != int'(cur.fail_at));
                if (req_kind == 2'd0) begin
                    reads = reads + 1;
                    resp_rdata = '0;
                    for (int i = 0; i < 4; i++) begin
                        resp_rdata[4*i] = (cur.cr_after != 0) && (reads >= int'(cur.cr_after)) && cur.cr_mask[i];
                        resp_rdata[16+4*i +: 4] = (i < lanes_n(cur.cfg)) ? adj_nib(cur.mode, reads) : 4'hF;
                    end
                end else if (req_kind == 2'd1) begin
                    chk("R1", "init pattern", {24'd0, req_pat}, 32'h21);
                    chk("R1", "init settings", req_wdata, 32'h0);
                end else begin
                    chk("R7", "setting bytes", req_wdata, {4{exp_set(cur.mode, reads)}});
                end
                resp_valid = 1'b1;
            end else begin
                resp_valid = 1'b0;
            end
        end
    end

    task automatic wait_done(output bit seen);
        int guard = 0;
        seen = 1'b0;
        while (done !== 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        seen = (done === 1'b1);
    endtask

    task automatic begin_phase(input vec_t v);
        cur       = v;
        req_n     = 0;
        reads     = 0;
        rev_ge_14 = v.rev;
        lane_cfg  = v.cfg;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R10: quiet outputs under reset.
        chk("R10", "busy in reset", {31'd0, busy}, 32'd0);
        chk("R10", "req in reset", {31'd0, req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "idle outputs", {28'd0, busy, done, pass, dly_start}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            begin_phase(TBL[i]);
            wait_done(seen);
            chk(vtag(i), $sformatf("vector %0d done seen", i), {31'd0, seen}, 32'd1);
            chk(vtag(i), $sformatf("vector %0d pass", i), {31'd0, pass}, {31'd0, TBL[i].exp_pass});
            chk(vtag(i), $sformatf("vector %0d status reads", i), reads, {24'd0, TBL[i].exp_reads});
            @(negedge clk);
            chk("R9", $sformatf("vector %0d done pulse ends", i), {31'd0, done}, 32'd0);
            chk("R9", $sformatf("vector %0d pass held", i), {31'd0, pass}, {31'd0, TBL[i].exp_pass});
            repeat (2) @(negedge clk);
        end

        // R9: a second start while busy must not restart the phase.
        begin_phase(TBL[5]);
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk("R9", "restart ignored reads", reads, 32'd5);
        chk("R9", "restart ignored pass", {31'd0, pass}, 32'd0);
        repeat (2) @(negedge clk);

        // R10: reset in mid-phase returns to idle.
        begin_phase(TBL[4]);
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "reset mid-phase", {29'd0, busy, req_valid, dly_start}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "idle after reset", {30'd0, busy, done}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

endmodule